// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block takes a bank of 32 level-sensitive interrupt request lines and presents them to a processor core. It drives three outputs: an interrupt request wire, an 8-bit vector bus and a separate non-maskable interrupt output. Software uses a small memory-mapped bus of 32-bit words. Through it, software writes an enable mask and reads the raw pending bits, the pending bits that pass the mask, and the non-maskable status.

The controller does not choose between pending sources. A lone enabled source produces a vector that identifies it. When two or more enabled sources are pending at once, the controller reports one shared vector, and the handler reads the masked pending word to decide the order itself. Lines 30 and 31 bypass the mask and feed the non-maskable path. Line 0 has no effect.

Top module: `vec_intc`

## Requirements
- R1: After reset every register reads 0, the request and non-maskable outputs are low and the vector is 0.
- R2: A write with `bus_widx` = 0 (byte offset 0x00) loads `bus_wdata` into the mask register. The mask reads back at index 0.
- R3: Writes with any other `bus_widx` leave every register unchanged.
- R4: Input line n, for n from 1 to 29, sets bit n-1 of the raw pending word (index 1, offset 0x04) while the line is high and clears it while the line is low. Bits 29 to 31 of that word read 0. Line 0 changes no register.
- R5: The masked pending word (index 2, offset 0x08) reads as the raw pending word ANDed bitwise with the mask.
- R6: When exactly one masked pending bit is set, at position i, the vector is 0x31 + i.
- R7: When two or more masked pending bits are set, the vector is 0x30.
- R8: When no masked pending bit is set, the vector is 0. `cpu_irq` is high exactly when the vector is nonzero.
- R9: Lines 30 and 31 set bits 30 and 31 of the non-maskable status word (index 3, offset 0x0C) whatever the mask holds. `cpu_nmi` is the OR of that word.
- R10: Index 4 (offset 0x10) and the unused indices 5 to 7 always read 0.
- R11: Registers and outputs take a new input or mask value at the first rising clock edge after the change. Reads return the register values as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt lines, one bit per line number |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_widx | input | 3 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| cpu_irq | output | 1 | Interrupt request to the core |
| cpu_vec | output | 8 | Interrupt vector to the core |
| cpu_nmi | output | 1 | Non-maskable interrupt to the core |

## Verification
The vector encoder is driven with every single line raised alone, then with adjacent and widely separated pairs. This separates the per-source vectors from the shared one and catches an off-by-one in the line-to-bit mapping. A sweep of single-bit masks with all lines high shows that the mask gates each position on its own, and that the bits with no source stay zero. Separate patterns on lines 0, 30 and 31 under a zero mask show that the non-maskable path bypasses the mask and that line 0 has no effect. A mid-cycle input change confirms the one-edge latency.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int DW = 32,
  parameter int VW = 8,
  parameter int IW = 3,
  parameter logic [VW-1:0] SHARED_VEC = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] irq_in,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [IW-1:0] bus_widx,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cpu_irq,
  output logic [VW-1:0] cpu_vec,
  output logic          cpu_nmi
);
  localparam int NMI_LO   = DW - 2;
  localparam int LAST_SRC = DW - 3;
  localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] SRC_MASK = ((ONE << (LAST_SRC + 1)) - ONE) & ~ONE;
  localparam logic [DW-1:0] NMI_MASK = ~((ONE << NMI_LO) - ONE);

  localparam logic [IW-1:0] IX_MASK   = IW'(0);
  localparam logic [IW-1:0] IX_RAW    = IW'(1);
  localparam logic [IW-1:0] IX_MASKED = IW'(2);
  localparam logic [IW-1:0] IX_NMI    = IW'(3);

  logic [DW-1:0] mask_q, raw_q, nmi_q;
  logic [DW-1:0] mask_d, raw_d, nmi_d, hit_d;
  logic [DW-1:0] masked;
  logic          wr_mask;

  function automatic logic [VW-1:0] encode(input logic [DW-1:0] m);
    logic [VW-1:0] v;
    int cnt;
    v = '0;
    cnt = 0;
    for (int i = 0; i < DW; i++) begin
      if (m[i]) begin
        cnt = cnt + 1;
        v = SHARED_VEC + VW'(i + 1);
      end
    end
    if (cnt > 1) v = SHARED_VEC;
    return v;
  endfunction

  assign wr_mask = bus_sel && bus_wr && (bus_widx == IX_MASK);
  assign mask_d  = wr_mask ? bus_wdata : mask_q;
  assign raw_d   = (irq_in & SRC_MASK) >> 1;
  assign nmi_d   = irq_in & NMI_MASK;
  assign hit_d   = raw_d & mask_d;
  assign masked  = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      raw_q   <= '0;
      nmi_q   <= '0;
      cpu_vec <= '0;
      cpu_irq <= 1'b0;
      cpu_nmi <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      raw_q   <= raw_d;
      nmi_q   <= nmi_d;
      cpu_vec <= encode(hit_d);
      cpu_irq <= |hit_d;
      cpu_nmi <= |nmi_d;
    end
  end

  always_comb begin
    case (bus_widx)
      IX_MASK:   bus_rdata = mask_q;
      IX_RAW:    bus_rdata = raw_q;
      IX_MASKED: bus_rdata = masked;
      IX_NMI:    bus_rdata = nmi_q;
      default:   bus_rdata = '0;
    endcase
  end

  p_irq_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (cpu_vec != '0));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (masked == '0) == (cpu_vec == '0));
  p_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked) > 1) |-> (cpu_vec == SHARED_VEC));
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked) == 1) |-> (cpu_vec > SHARED_VEC));
  p_nmi_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_nmi == (nmi_q != '0));
  p_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_sel && bus_wr && bus_widx != IX_MASK)) |-> (mask_q == $past(mask_q)));
  p_raw_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (raw_q[LAST_SRC-1:0] == $past(irq_in[LAST_SRC:1])));
  p_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[DW-1:LAST_SRC] == '0);
endmodule

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  logic [7:0]  cpu_vec;
  logic        cpu_nmi;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_intc u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_widx(bus_widx), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_nmi(cpu_nmi));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input logic [31:0] m);
    int c;
    int pos;
    c = $countones(m);
    pos = 0;
    for (int i = 0; i < 32; i++) if (m[i]) pos = i;
    if (c == 0) return 8'h00;
    if (c > 1) return 8'h30;
    return 8'(8'h31 + pos);
  endfunction

  function automatic logic [31:0] exp_raw(input logic [31:0] l);
    return (l >> 1) & 32'h1FFF_FFFF;
  endfunction

  task automatic rd(input logic [2:0] ix, output logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = ix;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ix, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = ix; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic drive(input logic [31:0] l);
    @(negedge clk);
    irq_in = l;
    @(negedge clk);
  endtask

  task automatic check_all(input string req, input logic [31:0] l, input logic [31:0] m);
    logic [31:0] v;
    logic [31:0] hm;
    hm = exp_raw(l) & m;
    rd(3'd1, v); check({req, " raw"}, v, exp_raw(l));
    rd(3'd2, v); check({req, " masked"}, v, hm);
    check({req, " vec"}, {24'h0, cpu_vec}, {24'h0, exp_vec(hm)});
    check({req, " R8 irq"}, {31'h0, cpu_irq}, {31'h0, exp_vec(hm) != 8'h00});
  endtask

  initial begin
    #(LIMIT * CLK_PERIOD);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    for (int ix = 0; ix < 8; ix++) begin
      rd(3'(ix), v); check("R1 reset read", v, 32'h0);
    end
    check("R1 reset outs", {22'h0, cpu_irq, cpu_nmi, cpu_vec}, 32'h0);
    rst_n = 1'b1;

    foreach (v[k]) begin end
    wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, v); check("R2 mask", v, 32'hA5A5_0F0F);
    wr(3'd0, 32'h1234_8001); rd(3'd0, v); check("R2 mask", v, 32'h1234_8001);
    for (int ix = 1; ix < 8; ix++) begin
      wr(3'(ix), 32'hFFFF_FFFF);
      rd(3'd0, v); check("R3 ignored write", v, 32'h1234_8001);
      rd(3'd4, v); check("R10 zero word", v, 32'h0);
      rd(3'd3, v); check("R3 nmi untouched", v, 32'h0);
    end
    for (int ix = 4; ix < 8; ix++) begin
      rd(3'(ix), v); check("R10 unused reads zero", v, 32'h0);
    end

    wr(3'd0, 32'hFFFF_FFFF);
    for (int n = 1; n < 30; n++) begin
      drive(32'h1 << n);
      check_all("R6 single", 32'h1 << n, 32'hFFFF_FFFF);
    end
    for (int n = 1; n < 29; n++) begin
      drive((32'h1 << n) | (32'h1 << (n + 1)));
      check_all("R7 pair", (32'h1 << n) | (32'h1 << (n + 1)), 32'hFFFF_FFFF);
    end
    drive(32'h2000_0002); check_all("R7 far pair", 32'h2000_0002, 32'hFFFF_FFFF);
    drive(32'h0);         check_all("R8 none", 32'h0, 32'hFFFF_FFFF);
    drive(32'h1);         check_all("R4 line0 ignored", 32'h1, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R4 line0 nmi", v, 32'h0);

    drive(32'h3FFF_FFFE);
    for (int j = 0; j < 32; j++) begin
      wr(3'd0, 32'h1 << j);
      check_all("R5 mask gate", 32'h3FFF_FFFE, 32'h1 << j);
    end
    wr(3'd0, 32'h0000_0410);
    check_all("R5 two bits", 32'h3FFF_FFFE, 32'h0000_0410);

    wr(3'd0, 32'h0);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] l;
      l = 32'(p) << 30;
      drive(l);
      rd(3'd3, v); check("R9 nmi status", v, l);
      check("R9 nmi out", {31'h0, cpu_nmi}, {31'h0, p != 0});
      check_all("R9 raw unaffected", l, 32'h0);
    end

    drive(32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    irq_in = 32'h20;
    #1 check("R11 before edge vec", {24'h0, cpu_vec}, 32'h0);
    rd(3'd1, v); check("R11 before edge raw", v, 32'h0);
    @(negedge clk);
    check("R11 after edge vec", {24'h0, cpu_vec}, 32'h35);
    rd(3'd1, v); check("R11 after edge raw", v, 32'h10);

    irq_in = 32'hC000_0040;
    rst_n = 1'b0;
    #1;
    check("R1 async reset outs", {22'h0, cpu_irq, cpu_nmi, cpu_vec}, 32'h0);
    rd(3'd0, v); check("R1 async reset mask", v, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule